// File: doc/BRIEF.md
# Text Row Index Fetcher with Processor Hold-Off

This block generates the pixel stream for a 40 by 25 character text screen built from 8x8 cells. The character codes live in shared RAM, which the processor also uses. The block reads each row's 40 codes only once. It does this on the first scanline of the row, and it holds the processor off the bus for that stretch of the line.

The codes go into a local row store. All eight scanlines of the row then read that store to form glyph-pattern addresses. So the seven later lines of a row never touch shared RAM. Each glyph byte comes back from an external pattern memory and is loaded into a shifter that puts out one pixel per clock.

The horizontal and vertical position counters come from the surrounding timing generator. A memory arbiter answers each index request with a grant. A request that is not granted still completes, but it fills its column with code zero.

Top module: `char_row_fetch`

## Requirements
- R1: After reset, `pixel_out` is 0 and `glyph_addr` is 0.
- R2: `cpu_stall` is high only on a row-first line, meaning `vcount` < 200 and `vcount` mod 8 = 0. On such a line it is high from `hcount` = H_OFS-STALL_LEAD up to and including `hcount` = H_OFS+312, the cycle of the 40th fetch. On every other line it stays low. Its rise therefore comes STALL_LEAD cycles before the first request.
- R3: On a row-first line, `mem_req` is high for exactly one cycle at `hcount` = H_OFS+8c, for c = 0 to 39. In that cycle `mem_addr` = `base_addr` + (`vcount`/8)*40 + c, taken modulo 2^16. Every request falls inside the stall window.
- R4: `mem_rdata` is taken in the cycle after a request. If `mem_gnt` was high in the request cycle, the byte is stored as the code for column c. If it was low, code 0 is stored instead.
- R5: On the seven other lines of a character row, and on lines with `vcount` >= 200, `mem_req` stays low. Those lines reuse the codes stored on the row's first line.
- R6: For column c on a line below 200, `glyph_addr` = code*8 + (`vcount` mod 8). The value is updated on the clock edge that ends `hcount` = H_OFS+8c+2, and changes on no other edge.
- R7: `glyph_data` is loaded on the edge that ends `hcount` = H_OFS+8c+7. During `hcount` = H_OFS+8c+8+k, `pixel_out` carries bit 7-k of that byte, so the most significant bit comes out first.
- R8: `pixel_out` is 0 outside columns 0 to 39 and on every line with `vcount` >= 200.

Ports table notes: GW in the Width column means glyph address width, which is 11 bits with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hcount | input | 9 | Pixel position within the line |
| vcount | input | 9 | Line number within the frame |
| base_addr | input | 16 | Start of the screen code area in shared RAM |
| mem_req | output | 1 | Index read request to the arbiter |
| mem_addr | output | 16 | Address of the index read |
| mem_gnt | input | 1 | Arbiter grant for the current request |
| mem_rdata | input | 8 | Read data, valid one cycle after a request |
| cpu_stall | output | 1 | Holds the processor off the shared bus |
| glyph_addr | output | GW | Pattern memory address: code and row within cell |
| glyph_data | input | 8 | Pattern byte for `glyph_addr` |
| pixel_out | output | 1 | Serial pixel |

## Verification
Two things can land in the same cycle: an index request that the arbiter refuses, and the replay of that column on the seven lines that follow. The bench drops `mem_gnt` at random on fetch cycles. It also drops it on purpose for the first and last columns of one row. Its own model of the row store puts code 0 into any refused column, and the pixel stream of every line in that row is compared against glyph patterns derived from that model. The bench also checks that the garbage it drives on `mem_rdata` outside reply cycles never reaches the screen.

// File: rtl/crf_pkg.sv
package crf_pkg;
    // Cell geometry and the slot phases that order the work for each column.
    localparam int CELL       = 8;
    localparam int CELL_LOG   = 3;
    localparam logic [2:0] PH_FETCH   = 3'd0;
    localparam logic [2:0] PH_CAPTURE = 3'd1;
    localparam logic [2:0] PH_GLYPH   = 3'd2;
    localparam logic [2:0] PH_LOAD    = 3'd7;
endpackage

// File: rtl/crf_timing.sv
module crf_timing
    import crf_pkg::*;
#(
    parameter int COLS       = 40,
    parameter int ROWS       = 25,
    parameter int H_OFS      = 8,
    parameter int STALL_LEAD = 3,
    parameter int HW         = 9,
    parameter int VW         = 9,
    parameter int COLW       = 6,
    parameter int ROWW       = 5
) (
    input  logic [HW-1:0]   hcount,
    input  logic [VW-1:0]   vcount,
    output logic            vis_line,
    output logic            first_line,
    output logic            slot_valid,
    output logic [COLW-1:0] slot,
    output logic [2:0]      phase,
    output logic [ROWW-1:0] row,
    output logic            stall_win
);
    localparam int SLW = HW - CELL_LOG;
    localparam logic [HW-1:0] H_FIRST   = HW'(H_OFS);
    localparam logic [HW-1:0] H_STALL0  = HW'(H_OFS - STALL_LEAD);
    localparam logic [HW-1:0] H_LASTFET = HW'(H_OFS + CELL * (COLS - 1));
    localparam logic [VW-1:0] V_VIS     = VW'(ROWS * CELL);
    localparam logic [SLW-1:0] SL_COLS  = SLW'(COLS);

    logic [HW-1:0]  h_rel;
    logic [SLW-1:0] slot_num;
    logic [VW-1:0]  v_row;

    always_comb begin
        h_rel      = hcount - H_FIRST;
        slot_num   = h_rel[HW-1:CELL_LOG];
        slot_valid = (hcount >= H_FIRST) && (slot_num < SL_COLS);
        slot       = slot_num[COLW-1:0];
        phase      = hcount[2:0];
        vis_line   = vcount < V_VIS;
        first_line = vis_line && (vcount[2:0] == 3'd0);
        v_row      = vcount >> CELL_LOG;
        row        = v_row[ROWW-1:0];
        stall_win  = first_line && (hcount >= H_STALL0) && (hcount <= H_LASTFET);
    end
endmodule

// File: rtl/crf_line_buf.sv
module crf_line_buf #(
    parameter int COLS  = 40,
    parameter int IDX_W = 8,
    parameter int COLW  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [COLW-1:0]  wr_col,
    input  logic [IDX_W-1:0] wr_code,
    input  logic [COLW-1:0]  rd_col,
    output logic [IDX_W-1:0] rd_code
);
    logic [IDX_W-1:0] code_q [COLS];
    logic [IDX_W-1:0] code_d [COLS];

    // One entry per column, each with its own write select.
    for (genvar g = 0; g < COLS; g++) begin : g_entry
        always_comb begin
            code_d[g] = code_q[g];
            if (wr_en && (wr_col == COLW'(g))) begin
                code_d[g] = wr_code;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q[g] <= '0;
            end else begin
                code_q[g] <= code_d[g];
            end
        end
    end

    always_comb begin
        rd_code = '0;
        for (int i = 0; i < COLS; i++) begin
            if (rd_col == COLW'(i)) begin
                rd_code = code_q[i];
            end
        end
    end
endmodule

// File: rtl/crf_shifter.sv
module crf_shifter #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PIX_W-1:0] load_bits,
    output logic             pix
);
    logic [PIX_W-1:0] sh_d, sh_q;

    always_comb begin
        if (load) begin
            sh_d = load_bits;
        end else begin
            sh_d = {sh_q[PIX_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign pix = sh_q[PIX_W-1];
endmodule

// File: rtl/char_row_fetch.sv
module char_row_fetch
    import crf_pkg::*;
#(
    parameter int COLS       = 40,
    parameter int ROWS       = 25,
    parameter int H_TOTAL    = 400,
    parameter int V_TOTAL    = 262,
    parameter int H_OFS      = 8,
    parameter int STALL_LEAD = 3,
    parameter int AW         = 16,
    parameter int IDX_W      = 8,
    localparam int HW        = $clog2(H_TOTAL),
    localparam int VW        = $clog2(V_TOTAL),
    localparam int GW        = IDX_W + CELL_LOG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HW-1:0]    hcount,
    input  logic [VW-1:0]    vcount,
    input  logic [AW-1:0]    base_addr,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_gnt,
    input  logic [IDX_W-1:0] mem_rdata,
    output logic             cpu_stall,
    output logic [GW-1:0]    glyph_addr,
    input  logic [CELL-1:0]  glyph_data,
    output logic             pixel_out
);
    localparam int COLW = $clog2(COLS);
    localparam int ROWW = $clog2(ROWS);

    typedef struct packed {
        logic            fetch_pend;
        logic            gnt_pend;
        logic [COLW-1:0] col_pend;
        logic [GW-1:0]   gaddr;
    } crf_state_t;

    crf_state_t st_d, st_q;

    logic            vis_line, first_line, slot_valid, stall_win;
    logic [COLW-1:0] slot;
    logic [2:0]      phase;
    logic [ROWW-1:0] row;
    logic [IDX_W-1:0] buf_wcode, buf_rcode;
    logic            sh_load;
    logic [CELL-1:0] sh_bits;

    crf_timing #(
        .COLS(COLS), .ROWS(ROWS), .H_OFS(H_OFS), .STALL_LEAD(STALL_LEAD),
        .HW(HW), .VW(VW), .COLW(COLW), .ROWW(ROWW)
    ) u_timing (
        .hcount(hcount), .vcount(vcount), .vis_line(vis_line),
        .first_line(first_line), .slot_valid(slot_valid), .slot(slot),
        .phase(phase), .row(row), .stall_win(stall_win)
    );

    crf_line_buf #(
        .COLS(COLS), .IDX_W(IDX_W), .COLW(COLW)
    ) u_line_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(st_q.fetch_pend),
        .wr_col(st_q.col_pend), .wr_code(buf_wcode),
        .rd_col(slot), .rd_code(buf_rcode)
    );

    crf_shifter #(
        .PIX_W(CELL)
    ) u_shifter (
        .clk(clk), .rst_n(rst_n), .load(sh_load),
        .load_bits(sh_bits), .pix(pixel_out)
    );

    always_comb begin
        st_d = st_q;

        // Index fetch: one read per column slot on the row's first line.
        mem_req   = first_line && slot_valid && (phase == PH_FETCH);
        mem_addr  = base_addr + (AW'(row) * AW'(COLS)) + AW'(slot);
        cpu_stall = stall_win;

        st_d.fetch_pend = mem_req;
        st_d.gnt_pend   = mem_gnt;
        st_d.col_pend   = slot;

        // Refused request leaves a blank code in its column.
        buf_wcode = st_q.gnt_pend ? mem_rdata : '0;

        // Glyph address from the stored code and the line within the cell.
        if (vis_line && slot_valid && (phase == PH_GLYPH)) begin
            st_d.gaddr = {buf_rcode, vcount[CELL_LOG-1:0]};
        end

        sh_load = (phase == PH_LOAD);
        sh_bits = (vis_line && slot_valid) ? glyph_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign glyph_addr = st_q.gaddr;
endmodule

// File: rtl/crf_checker.sv
module crf_checker #(
    parameter int GW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    phase,
    input logic [2:0]    subline,
    input logic          mem_req,
    input logic          cpu_stall,
    input logic [GW-1:0] glyph_addr
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    AST_REQ_INSIDE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_stall); // R3

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R3

    AST_STALL_LEADS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(cpu_stall)) |-> !mem_req); // R2

    AST_NO_REPLAY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (subline == 3'd0)); // R5

    AST_GLYPH_UPDATE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$stable(glyph_addr)) |-> ($past(phase) == 3'd2)); // R6
endmodule

bind char_row_fetch crf_checker #(.GW(GW)) u_crf_checker (
    .clk(clk), .rst_n(rst_n), .phase(hcount[2:0]), .subline(vcount[2:0]),
    .mem_req(mem_req), .cpu_stall(cpu_stall), .glyph_addr(glyph_addr)
);

// File: tb/char_row_fetch_bench.sv
module char_row_fetch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int H_TOTAL = 400;
    localparam int H_OFS   = 8;
    localparam int LEAD    = 3;
    localparam int COLS    = 40;
    localparam int VIS     = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  hcount = '0;
    logic [8:0]  vcount = '0;
    logic [15:0] base_addr = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_gnt = 1'b1;
    logic [7:0]  mem_rdata = '0;
    logic        cpu_stall;
    logic [10:0] glyph_addr;
    logic [7:0]  glyph_data = '0;
    logic        pixel_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0]  mbuf [COLS];
    bit          pend;
    bit          pend_gnt;
    int          pend_col;
    logic [15:0] pend_addr;
    logic [7:0]  salt;

    always #(CLK_PERIOD/2) clk = ~clk;

    char_row_fetch u_char_row_fetch (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
        .base_addr(base_addr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .cpu_stall(cpu_stall),
        .glyph_addr(glyph_addr), .glyph_data(glyph_data), .pixel_out(pixel_out)
    );

    function automatic logic [7:0] memval(input logic [15:0] a);
        logic [7:0] x;
        x = a[7:0] ^ a[15:8] ^ salt;
        x = x * 8'd29 + 8'd7;
        return (x[2:0] == 3'd5) ? 8'd0 : x;
    endfunction

    function automatic logic [7:0] rom(input logic [10:0] a);
        logic [7:0] y;
        if (a[10:3] == 8'd0) return 8'd0;
        y = a[7:0] * 8'd151;
        return y ^ a[10:3] ^ 8'h5a;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // One clock cycle at position (h, v); gnt_force: -1 random, else fixed.
    task automatic step(input int h, input int v, input int gnt_force);
        bit first, exp_stall, exp_req, vis;
        int hr, c, k;
        logic [7:0]  g;
        logic [15:0] exp_addr;
        @(negedge clk);
        hcount = 9'(h);
        vcount = 9'(v);
        if (gnt_force < 0) mem_gnt = ($urandom % 10) != 0;
        else mem_gnt = gnt_force[0];
        // Reply to the previous request, garbage otherwise.
        if (pend) begin
            mem_rdata = memval(pend_addr);
            mbuf[pend_col] = pend_gnt ? memval(pend_addr) : 8'd0;
        end else begin
            mem_rdata = 8'($urandom);
        end
        pend = 1'b0;
        glyph_data = rom(glyph_addr);
        #1;
        vis       = v < VIS;
        first     = vis && (v % 8 == 0);
        exp_stall = first && h >= H_OFS - LEAD && h <= H_OFS + 8 * (COLS - 1);
        exp_req   = first && h >= H_OFS && h < H_OFS + 8 * COLS && ((h - H_OFS) % 8 == 0);
        check(cpu_stall == exp_stall, "R2 stall", cpu_stall, exp_stall);
        check(mem_req == exp_req, exp_req ? "R3 request" : "R5 no request", mem_req, exp_req);
        if (exp_req) begin
            c = (h - H_OFS) / 8;
            exp_addr = base_addr + 16'(v / 8) * 16'd40 + 16'(c);
            check(mem_addr == exp_addr, "R3 address", mem_addr, exp_addr);
            pend = 1'b1;
            pend_gnt = mem_gnt;
            pend_col = c;
            pend_addr = exp_addr;
        end
        if (vis && h >= H_OFS && h < H_OFS + 8 * COLS && ((h - H_OFS) % 8 == 3)) begin
            c = (h - H_OFS) / 8;
            check(glyph_addr == {mbuf[c], 3'(v)}, "R6 glyph address (R4 code)",
                  glyph_addr, {mbuf[c], 3'(v)});
        end
        hr = h - H_OFS - 8;
        if (vis && hr >= 0 && hr < 8 * COLS) begin
            c = hr / 8;
            k = hr % 8;
            g = rom({mbuf[c], 3'(v)});
            check(pixel_out == g[7 - k], "R7 pixel (R4 code)", pixel_out, g[7 - k]);
        end else begin
            check(pixel_out == 1'b0, "R8 blank", pixel_out, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < COLS; i++) mbuf[i] = 8'd0;
        pend = 1'b0;
        salt = 8'h3c;
        base_addr = 16'hfe80;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(pixel_out == 1'b0, "R1 reset pixel", pixel_out, 0);
        check(glyph_addr == 11'd0, "R1 reset glyph", glyph_addr, 0);

        // Full frame with random refusals; row 3 loses its first and last column.
        for (int v = 0; v < 205; v++) begin
            for (int h = 0; h < H_TOTAL; h++) begin
                if (v == 24 && (h == H_OFS || h == H_OFS + 8 * (COLS - 1)))
                    step(h, v, 0);
                else
                    step(h, v, -1);
            end
        end

        // Second frame: new base and contents, all grants, then the last rows.
        salt = 8'ha7;
        base_addr = 16'h0400;
        for (int v = 0; v < 16; v++)
            for (int h = 0; h < H_TOTAL; h++) step(h, v, 1);
        for (int v = 192; v < 208; v++)
            for (int h = 0; h < H_TOTAL; h++) step(h, v, -1);

        done = 1'b1;
        summary();
    end
endmodule